// File: doc/BRIEF.md
# In-Band Loopback Code Detector

This block watches a received T1 bit stream for a repeating loopback code. It watches for two codes at the same time, one that asks for activation and one that asks for deactivation. Each code is 5 to 8 bits long and is set by a length select and an 8-bit pattern. The stream may be framed or unframed. In framed mode a marker input flags the framing-bit position, and a configuration bit decides whether that position takes part in the comparison.

Each code has its own tracker, and each tracker first hunts for alignment. After four back-to-back clean repetitions it locks to the code phase and starts counting bit errors over fixed measurement periods, which are counted in received bits. After enough consecutive low-error periods the code's status bit rises. One high-error period clears the status bit, and the tracker goes back to hunting. Every change of a status bit sets a sticky flag for that code. Each flag has an enable, and the enabled flags are ORed onto one interrupt output.

Top module: `inband_loop_detect`

## Requirements
- R1: The length select maps 0, 1, 2 and 3 to code lengths of 5, 6, 7 and 8 bits. The code is the top bits of the pattern, sent most significant bit first: pattern bit 7 is the first bit of each repetition.
- R2: A tracker in hunt locks only after four consecutive error-free repetitions of its code among the compared bits. Error monitoring starts with the next received bit.
- R3: A measurement period is PERIOD_BITS received bits. The first period starts at the first bit after lock. A period with fewer than ERR_LIMIT bit errors is good, where a bit error is a compared bit that differs from the expected code bit.
- R4: The status bit rises on the last bit of the (GOOD_PERIODS+1)-th consecutive good period after lock, and not earlier.
- R5: A period with ERR_LIMIT or more errors clears the status bit on its last bit. The tracker then returns to hunt and needs four clean repetitions and a new run of good periods before the status bit can rise again.
- R6: With `framed` low, `fbit_mark` has no effect and every received bit is compared.
- R7: With `framed` high and `fbit_cmp` low, a bit marked by `fbit_mark` is skipped: it does not consume a code position and its value is ignored. It still counts toward the period length.
- R8: With `framed` high and `fbit_cmp` high, a marked bit consumes a code position. Once locked, a mismatch on a marked bit never counts as an error.
- R9: Any change of a status bit sets that code's flag one cycle later. The flag stays set until its clear input is pulsed, and a new change wins over a clear in the same cycle.
- R10: `irq` is the registered OR of each flag ANDed with its enable.
- R11: The activate and deactivate trackers act independently. A stream carrying one code leaves the other code's status bit and flag at zero.
- R12: Reset drives both status bits, both flags and `irq` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rx_valid | input | 1 | A received bit is present this cycle |
| rx_bit | input | 1 | Received bit value |
| fbit_mark | input | 1 | Current bit is the framing-bit position |
| framed | input | 1 | 1 for framed stream, 0 for unframed |
| fbit_cmp | input | 1 | Framed mode: the framing position takes a code position |
| act_len | input | 2 | Activate code length select |
| act_code | input | 8 | Activate code pattern, MSB first |
| deact_len | input | 2 | Deactivate code length select |
| deact_code | input | 8 | Deactivate code pattern, MSB first |
| act_irq_en | input | 1 | Enable of the activate flag onto irq |
| deact_irq_en | input | 1 | Enable of the deactivate flag onto irq |
| act_clr | input | 1 | Clear pulse for the activate flag |
| deact_clr | input | 1 | Clear pulse for the deactivate flag |
| act_status | output | 1 | Activate code detected |
| deact_status | output | 1 | Deactivate code detected |
| act_flag | output | 1 | Sticky change flag of the activate status |
| deact_flag | output | 1 | Sticky change flag of the deactivate status |
| irq | output | 1 | Interrupt output |

## Verification
The bench builds the block with PERIOD_BITS of 64, ERR_LIMIT of 4 and GOOD_PERIODS of 3. With these values a complete lock, rise, loss and relock sequence fits within a few hundred bits, so the exact bit on which each status edge falls can be sampled from both sides. The small error limit lets random error counts just below the limit and exactly at it be placed inside a single period. It also means that one wrong framing bit every five bits would exceed the limit if such bits were counted, which makes the framing-bit exemption observable.

// File: rtl/lcd_pkg.sv
package lcd_pkg;
  typedef enum logic {ST_HUNT = 1'b0, ST_WATCH = 1'b1} trk_state_e;

  localparam int CODE_W = 8;

  // length select 0..3 gives 5..8 bits
  function automatic logic [3:0] len_of(input logic [1:0] sel);
    return 4'd5 + {2'b00, sel};
  endfunction
endpackage

// File: rtl/lcd_qualify.sv
module lcd_qualify (
  input  logic rx_valid,
  input  logic fbit_mark,
  input  logic framed,
  input  logic fbit_cmp,
  output logic take,
  output logic exempt
);
  // a bit consumes a code position unless it is a skipped framing slot
  assign take   = rx_valid && !(framed && fbit_mark && !fbit_cmp);
  // framing slot comparisons never become errors
  assign exempt = framed && fbit_mark;
endmodule

// File: rtl/lcd_tracker.sv
module lcd_tracker import lcd_pkg::*; #(
  parameter int PERIOD_BITS  = 61450,
  parameter int ERR_LIMIT    = 600,
  parameter int GOOD_PERIODS = 126
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rx_valid,
  input  logic              take,
  input  logic              exempt,
  input  logic              rx_bit,
  input  logic [1:0]        len_sel,
  input  logic [CODE_W-1:0] pattern,
  output logic              status
);
  localparam int PW = $clog2(PERIOD_BITS);
  localparam int EW = $clog2(ERR_LIMIT + 1);
  localparam int GW = $clog2(GOOD_PERIODS + 2);
  localparam logic [PW-1:0] PER_LAST = PW'(PERIOD_BITS - 1);
  localparam logic [EW-1:0] ERR_TOP  = EW'(ERR_LIMIT);
  localparam logic [GW-1:0] GOOD_TOP = GW'(GOOD_PERIODS + 1);

  trk_state_e        state;
  logic [7:0]        hist;
  logic [3:0]        fill;
  logic [1:0]        reps;
  logic [3:0]        gap;
  logic [2:0]        phase;
  logic [PW-1:0]     per_cnt;
  logic [EW-1:0]     err_cnt;
  logic [GW-1:0]     good_cnt;

  logic [3:0]        len;
  logic [7:0]        hist_nxt;
  logic [3:0]        fill_nxt;
  logic [7:0]        aligned;
  logic [7:0]        len_mask;
  logic              win_match;
  logic              exp_bit;
  logic              bit_err;
  logic [EW-1:0]     err_sum;
  logic              period_end;
  logic              period_bad;
  logic              phase_last;

  always_comb begin
    len        = len_of(len_sel);
    hist_nxt   = {hist[6:0], rx_bit};
    fill_nxt   = (fill < 4'd8) ? fill + 4'd1 : fill;
    aligned    = pattern >> (4'd8 - len);
    len_mask   = 8'hFF >> (4'd8 - len);
    win_match  = (((hist_nxt ^ aligned) & len_mask) == 8'h00) && (fill_nxt >= len);
    exp_bit    = pattern[3'd7 - phase];
    bit_err    = take && !exempt && (rx_bit != exp_bit);
    err_sum    = (err_cnt == ERR_TOP) ? ERR_TOP : err_cnt + EW'(bit_err);
    period_end = rx_valid && (state == ST_WATCH) && (per_cnt == PER_LAST);
    period_bad = (err_sum >= ERR_TOP);
    phase_last = ({1'b0, phase} == len - 4'd1);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= ST_HUNT;
      hist     <= '0;
      fill     <= '0;
      reps     <= '0;
      gap      <= '0;
      phase    <= '0;
      per_cnt  <= '0;
      err_cnt  <= '0;
      good_cnt <= '0;
      status   <= 1'b0;
    end else begin
      if (take) begin
        hist <= hist_nxt;
        fill <= fill_nxt;
      end
      case (state)
        ST_HUNT: begin
          if (take) begin
            if (reps == 2'd0) begin
              if (win_match) begin
                reps <= 2'd1;
                gap  <= 4'd1;
              end
            end else if (gap == len) begin
              if (!win_match) begin
                reps <= 2'd0;
              end else if (reps == 2'd3) begin
                state    <= ST_WATCH;
                phase    <= '0;
                per_cnt  <= '0;
                err_cnt  <= '0;
                good_cnt <= '0;
                reps     <= 2'd0;
              end else begin
                reps <= reps + 2'd1;
                gap  <= 4'd1;
              end
            end else begin
              gap <= gap + 4'd1;
            end
          end
        end
        ST_WATCH: begin
          if (rx_valid) begin
            if (take) phase <= phase_last ? 3'd0 : phase + 3'd1;
            if (period_end) begin
              per_cnt <= '0;
              err_cnt <= '0;
              if (period_bad) begin
                state    <= ST_HUNT;
                status   <= 1'b0;
                good_cnt <= '0;
                reps     <= 2'd0;
                gap      <= 4'd0;
              end else begin
                if (good_cnt != GOOD_TOP) good_cnt <= good_cnt + GW'(1);
                if (good_cnt == GOOD_TOP - GW'(1)) status <= 1'b1;
              end
            end else begin
              per_cnt <= per_cnt + PW'(1);
              err_cnt <= err_sum;
            end
          end
        end
        default: state <= ST_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/lcd_irq.sv
module lcd_irq #(
  parameter int N = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] status,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] en,
  output logic [N-1:0] flag,
  output logic         irq
);
  logic [N-1:0] status_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      status_d <= '0;
      flag     <= '0;
      irq      <= 1'b0;
    end else begin
      status_d <= status;
      flag     <= (status ^ status_d) | (flag & ~clr);
      irq      <= |(flag & en);
    end
  end
endmodule

// File: rtl/inband_loop_detect.sv
module inband_loop_detect import lcd_pkg::*; #(
  parameter int PERIOD_BITS  = 61450,
  parameter int ERR_LIMIT    = 600,
  parameter int GOOD_PERIODS = 126
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       rx_valid,
  input  logic       rx_bit,
  input  logic       fbit_mark,
  input  logic       framed,
  input  logic       fbit_cmp,
  input  logic [1:0] act_len,
  input  logic [7:0] act_code,
  input  logic [1:0] deact_len,
  input  logic [7:0] deact_code,
  input  logic       act_irq_en,
  input  logic       deact_irq_en,
  input  logic       act_clr,
  input  logic       deact_clr,
  output logic       act_status,
  output logic       deact_status,
  output logic       act_flag,
  output logic       deact_flag,
  output logic       irq
);
  localparam int NCODE = 2;

  logic              take;
  logic              exempt;
  logic [1:0]        sel_a [NCODE];
  logic [CODE_W-1:0] pat_a [NCODE];
  logic [NCODE-1:0]  stat_v;
  logic [NCODE-1:0]  flag_v;

  assign sel_a[0] = act_len;
  assign sel_a[1] = deact_len;
  assign pat_a[0] = act_code;
  assign pat_a[1] = deact_code;

  lcd_qualify u_qual (
    .rx_valid  (rx_valid),
    .fbit_mark (fbit_mark),
    .framed    (framed),
    .fbit_cmp  (fbit_cmp),
    .take      (take),
    .exempt    (exempt)
  );

  for (genvar g = 0; g < NCODE; g++) begin : g_trk
    lcd_tracker #(
      .PERIOD_BITS  (PERIOD_BITS),
      .ERR_LIMIT    (ERR_LIMIT),
      .GOOD_PERIODS (GOOD_PERIODS)
    ) u_trk (
      .clk      (clk),
      .rst      (rst),
      .rx_valid (rx_valid),
      .take     (take),
      .exempt   (exempt),
      .rx_bit   (rx_bit),
      .len_sel  (sel_a[g]),
      .pattern  (pat_a[g]),
      .status   (stat_v[g])
    );
  end

  lcd_irq #(.N(NCODE)) u_irq (
    .clk    (clk),
    .rst    (rst),
    .status (stat_v),
    .clr    ({deact_clr, act_clr}),
    .en     ({deact_irq_en, act_irq_en}),
    .flag   (flag_v),
    .irq    (irq)
  );

  assign act_status   = stat_v[0];
  assign deact_status = stat_v[1];
  assign act_flag     = flag_v[0];
  assign deact_flag   = flag_v[1];
endmodule

// File: rtl/lcd_checker.sv
module lcd_checker (
  input logic clk,
  input logic rst,
  input logic rx_valid,
  input logic act_status,
  input logic deact_status,
  input logic act_flag,
  input logic deact_flag,
  input logic act_clr,
  input logic deact_clr,
  input logic act_irq_en,
  input logic deact_irq_en,
  input logic irq
);
  // R12
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (!act_status && !deact_status && !irq));

  // R9
  act_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (act_status != $past(act_status)) |=> act_flag);

  // R9
  deact_flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (deact_status != $past(deact_status)) |=> deact_flag);

  // R9
  act_flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (act_flag && !act_clr) |=> act_flag);

  // R9
  deact_flag_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (deact_flag && !deact_clr) |=> deact_flag);

  // R10
  irq_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    (!act_flag && !deact_flag) |=> !irq);

  // R10
  irq_raise_chk: assert property (@(posedge clk) disable iff (rst)
    ((act_flag && act_irq_en) || (deact_flag && deact_irq_en)) |=> irq);

  // R4
  act_move_chk: assert property (@(posedge clk) disable iff (rst)
    (act_status != $past(act_status)) |-> $past(rx_valid));

  // R5
  deact_move_chk: assert property (@(posedge clk) disable iff (rst)
    (deact_status != $past(deact_status)) |-> $past(rx_valid));
endmodule

bind inband_loop_detect lcd_checker u_chk (.*);

// File: tb/sim_inband_loop_detect.sv
`timescale 1ns/100ps
module sim_inband_loop_detect;
  localparam int P   = 64;
  localparam int LIM = 4;
  localparam int GP  = 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rx_valid = 1'b0, rx_bit = 1'b0, fbit_mark = 1'b0;
  logic framed = 1'b0, fbit_cmp = 1'b0;
  logic [1:0] act_len = 2'd0, deact_len = 2'd0;
  logic [7:0] act_code = 8'h00, deact_code = 8'h00;
  logic act_irq_en = 1'b0, deact_irq_en = 1'b0, act_clr = 1'b0, deact_clr = 1'b0;
  logic act_status, deact_status, act_flag, deact_flag, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  // stream generator state
  int pos = 0;
  int rxn = 0;
  logic [7:0] pat_g = 8'h80;
  int len_g = 5;
  int fmode = 0;   // 0 unframed, 1 framed skip, 2 framed compared
  int fsp = 9;
  bit fwrong = 1'b0;
  int seed_v;

  always #2.5 clk = ~clk;

  inband_loop_detect #(.PERIOD_BITS(P), .ERR_LIMIT(LIM), .GOOD_PERIODS(GP)) u0 (
    .clk(clk), .rst(rst), .rx_valid(rx_valid), .rx_bit(rx_bit), .fbit_mark(fbit_mark),
    .framed(framed), .fbit_cmp(fbit_cmp), .act_len(act_len), .act_code(act_code),
    .deact_len(deact_len), .deact_code(deact_code), .act_irq_en(act_irq_en),
    .deact_irq_en(deact_irq_en), .act_clr(act_clr), .deact_clr(deact_clr),
    .act_status(act_status), .deact_status(deact_status), .act_flag(act_flag),
    .deact_flag(deact_flag), .irq(irq)
  );

  task automatic chk(input string tag, input logic actual, input logic expected);
    checks++;
    if (actual !== expected) begin
      errors++;
      $display("FAIL %s actual %b expected %b", tag, actual, expected);
    end
  endtask

  task automatic settle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    settle(3);
    rst = 1'b0;
    pos = 0;
    rxn = 0;
    fwrong = 1'b0;
  endtask

  task automatic send(input logic b, input logic f);
    @(negedge clk);
    rx_valid  = 1'b1;
    rx_bit    = b;
    fbit_mark = f;
    @(negedge clk);
    rx_valid  = 1'b0;
    fbit_mark = 1'b0;
  endtask

  function automatic logic code_bit(input logic [7:0] pat, input int len, input int p);
    return pat[7 - (p % len)];
  endfunction

  task automatic tx(input bit flip);
    bit isf;
    logic b;
    if (fmode != 0) isf = ((rxn % fsp) == fsp - 1);
    else isf = (($urandom % 7) == 0);
    if (fmode == 1 && isf) begin
      b = 1'($urandom % 2);
    end else begin
      b = code_bit(pat_g, len_g, pos) ^ flip;
      if (fmode == 2 && isf && fwrong) b = ~b;
      pos++;
    end
    send(b, isf);
    rxn++;
  endtask

  task automatic tx_block(input int n, input int nerr);
    int ep[8];
    for (int j = 0; j < nerr; j++) begin
      bit dup;
      do begin
        ep[j] = int'($urandom % n);
        dup = 1'b0;
        for (int q = 0; q < j; q++) if (ep[q] == ep[j]) dup = 1'b1;
      end while (dup);
    end
    for (int i = 0; i < n; i++) begin
      bit fl;
      fl = 1'b0;
      for (int j = 0; j < nerr; j++) if (ep[j] == i) fl = 1'b1;
      tx(fl);
    end
  endtask

  task automatic lock_stream();
    while (pos < 4 * len_g) tx(1'b0);
  endtask

  // watchdog
  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    seed_v = $urandom(32'd2024);
    // ---------------- scenario A: activate code, unframed ----------------
    act_len = 2'd0; act_code = 8'b1000_0000;      // R1: 10000
    deact_len = 2'd1; deact_code = 8'b1001_0000;  // 100100
    act_irq_en = 1'b1; deact_irq_en = 1'b1;
    framed = 1'b0; fbit_cmp = 1'b0;
    pat_g = act_code; len_g = 5; fmode = 0;
    do_reset();
    chk("R12 act_status after reset", act_status, 1'b0);
    chk("R12 deact_status after reset", deact_status, 1'b0);
    chk("R12 act_flag after reset", act_flag, 1'b0);
    chk("R12 irq after reset", irq, 1'b0);
    lock_stream();                                 // R2, R6 (marks ignored)
    for (int k = 0; k < GP; k++) tx_block(P, int'($urandom % LIM));
    tx_block(P - 1, int'($urandom % LIM));
    chk("R4 act_status one bit before rise", act_status, 1'b0);
    tx(1'b0);
    chk("R4 act_status on rise bit", act_status, 1'b1);
    settle(3);
    chk("R9 act_flag after rise", act_flag, 1'b1);
    chk("R10 irq with flag enabled", irq, 1'b1);
    chk("R11 deact_status untouched", deact_status, 1'b0);
    chk("R11 deact_flag untouched", deact_flag, 1'b0);
    act_irq_en = 1'b0;
    settle(3);
    chk("R10 irq masked by enable", irq, 1'b0);
    chk("R9 act_flag sticky while masked", act_flag, 1'b1);
    @(negedge clk); act_clr = 1'b1;
    @(negedge clk); act_clr = 1'b0;
    settle(2);
    chk("R9 act_flag cleared", act_flag, 1'b0);
    act_irq_en = 1'b1;
    tx_block(P, LIM - 1);
    chk("R3 status kept at limit minus one errors", act_status, 1'b1);
    tx_block(P - 1, LIM);
    chk("R5 status before bad period ends", act_status, 1'b1);
    tx(1'b0);
    chk("R5 status cleared on bad period end", act_status, 1'b0);
    settle(3);
    chk("R9 act_flag on fall", act_flag, 1'b1);
    chk("R10 irq on fall", irq, 1'b1);
    tx_block(4 * P, 0);
    chk("R5 relock needed before rise", act_status, 1'b0);
    tx_block(5 * len_g, 0);
    chk("R5 status back after relock", act_status, 1'b1);

    // ---------------- scenario B: deactivate code ----------------
    act_len = 2'd0; act_code = 8'b1100_0000;
    deact_len = 2'd1; deact_code = 8'b1001_0000;
    act_irq_en = 1'b0; deact_irq_en = 1'b1;
    pat_g = deact_code; len_g = 6; fmode = 0;
    do_reset();
    lock_stream();
    tx_block(4 * P - 1, 0);
    chk("R11 deact_status before rise", deact_status, 1'b0);
    tx(1'b0);
    chk("R11 deact_status on rise bit", deact_status, 1'b1);
    settle(3);
    chk("R11 act_status stays low", act_status, 1'b0);
    chk("R11 act_flag stays low", act_flag, 1'b0);
    chk("R10 irq from deact flag", irq, 1'b1);

    // ---------------- scenario C: random codes and lengths ----------------
    act_irq_en = 1'b1;
    for (int it = 0; it < 10; it++) begin
      logic [1:0] s;
      logic [7:0] p;
      s = 2'($urandom % 4);
      p = 8'($urandom);
      act_len = s; act_code = p; deact_len = s; deact_code = p;
      pat_g = p; len_g = 5 + int'(s); fmode = 0;
      do_reset();
      lock_stream();
      for (int k = 0; k < GP; k++) tx_block(P, int'($urandom % LIM));
      tx_block(P - 1, int'($urandom % LIM));
      chk("R1 R4 random code act before rise", act_status, 1'b0);
      chk("R1 R4 random code deact before rise", deact_status, 1'b0);
      tx(1'b0);
      chk("R1 R4 random code act on rise", act_status, 1'b1);
      chk("R1 R4 random code deact on rise", deact_status, 1'b1);
      tx_block(P, LIM + int'($urandom % 3));
      chk("R5 random code loss", act_status, 1'b0);
    end

    // ---------------- scenario D: framed, framing slot skipped ----------------
    act_len = 2'd2; act_code = 8'b1011_0010;
    deact_len = 2'd2; deact_code = 8'b1011_0010;
    framed = 1'b1; fbit_cmp = 1'b0;
    pat_g = act_code; len_g = 7; fmode = 1; fsp = 9;
    do_reset();
    lock_stream();
    tx_block(4 * P - 1, 0);
    chk("R7 skipped slots, before rise", act_status, 1'b0);
    tx(1'b0);
    chk("R7 skipped slots, on rise", act_status, 1'b1);

    // ---------------- scenario E: framed, framing slot compared ----------------
    act_len = 2'd3; act_code = 8'b1110_0100;
    deact_len = 2'd3; deact_code = 8'b1110_0100;
    framed = 1'b1; fbit_cmp = 1'b1;
    pat_g = act_code; len_g = 8; fmode = 2; fsp = 5;
    do_reset();
    lock_stream();
    fwrong = 1'b1;   // every framing slot now mismatches
    tx_block(4 * P - 1, 0);
    chk("R8 wrong framing bits, before rise", act_status, 1'b0);
    tx(1'b0);
    chk("R8 wrong framing bits not counted", act_status, 1'b1);
    tx_block(2 * P, 0);
    chk("R8 status kept under wrong framing bits", act_status, 1'b1);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule